// File: doc/BRIEF.md
# Debounced Input Event Capture Unit

This block watches sixteen digital input lines. Each line is first brought into the clock domain by a two-stage synchronizer. It then passes through its own debounce counter, so a level change is accepted only once it has lasted long enough. Software can read the accepted levels at any time.

The accepted levels drive a change detector for each input. A two-bit field per input selects which edges count: rising, falling, both, or none. A counted edge sets a sticky event bit. That bit stays set, and ignores further edges, until software writes a one to it. An enable mask selects which event bits may raise the interrupt. The interrupt stays high as long as any enabled event bit is set.

All control and status registers sit behind a small byte-wide bus. Reads return data one cycle after the address is presented.

Top module: `din_event_unit`

## Requirements
- R1: After synchronous reset, the status, event and enable registers read zero, all edge selects are 00, the debounce reload is 8, and `irq` is low.
- R2: The debounced level of input i reads at offset 1 for i in 0..7 (bit i) and at offset 2 for i in 8..15 (bit i-8). Read data appears one clock after the address.
- R3: Let L be the reload value (low byte at offset 0, high byte at offset 11). After the synchronizer, a new raw level must persist for L+1 consecutive cycles before the status bit changes. A shorter pulse never reaches the status register.
- R4: Edge select bytes sit at offsets 7..10. Byte 7+k holds inputs 4k..4k+3, and input 4k+j uses bits 2j+1:2j. The codes are 00 none, 01 rising, 10 falling, 11 both.
- R5: A selected change of a debounced level sets that input's event bit. Event bits read at offset 3 (inputs 7..0) and offset 4 (inputs 15..8).
- R6: A set event bit holds one event only. Further edges on that input leave it set, and no other bit changes because of them.
- R7: Writing offsets 3/4 clears each event bit whose data bit is 1. Data bits of 0 leave their event bits unchanged.
- R8: When a selected edge and a clearing write hit the same event bit in the same cycle, the bit ends up set.
- R9: Interrupt enables sit at offsets 5 (inputs 7..0) and 6 (inputs 15..8). `irq` is high one clock after any enabled event bit is set. It falls only after every enabled set event bit has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | 16 | Asynchronous digital inputs |
| bus_addr | input | 4 | Register byte offset |
| bus_we | input | 1 | Write strobe for the current offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the previous cycle's offset |
| irq | output | 1 | Level interrupt request |

## Verification
A debounce counter in the wrong state shows up at the status offsets. The accepted level changes too early, too late, or after a glitch, and the error is visible within a few cycles of the threshold of L+1 synchronized cycles. A wrong event latch shows up at offsets 3/4 and, through the enable mask, on `irq` one cycle later. The latch may miss an edge, count an unselected one, lose a bit to a zero write, or drop a bit when a clear collides with an edge. The checks compare the ports against a bench model that tracks levels, selects, events and enables.

// File: rtl/din_evt_pkg.sv
package din_evt_pkg;
  localparam int N_IN        = 16;
  localparam int DEB_W       = 16;
  localparam int ADDR_W      = 4;
  localparam int NB          = N_IN / 8;
  localparam int NSEL_B      = (2 * N_IN) / 8;
  localparam int DEB_DEFAULT = 8;

  localparam int OFS_RL_LO = 0;
  localparam int OFS_ST    = 1;
  localparam int OFS_EV    = 3;
  localparam int OFS_EN    = 5;
  localparam int OFS_SEL   = 7;
  localparam int OFS_RL_HI = 11;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/din_evt_sync.sv
module din_evt_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      q    <= '0;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/din_evt_debounce.sv
module din_evt_debounce #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_sync,
  input  logic [CNT_W-1:0] reload,
  output logic             level,
  output logic             rise,
  output logic             fall
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      cnt_q <= '0;
      rise  <= 1'b0;
      fall  <= 1'b0;
    end else begin
      rise <= 1'b0;
      fall <= 1'b0;
      if (in_sync == level) begin
        cnt_q <= reload;
      end else if (cnt_q == '0) begin
        level <= in_sync;
        cnt_q <= reload;
        rise  <= in_sync;
        fall  <= ~in_sync;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R3: an input that agrees with the accepted level never moves it
  p_hold_level_r3: assert property (@(posedge clk) disable iff (rst)
    (in_sync == level) |=> $stable(level));
  // R3: change pulses agree with the new level
  p_rise_level_r3: assert property (@(posedge clk) disable iff (rst)
    rise |-> level);
  p_fall_level_r3: assert property (@(posedge clk) disable iff (rst)
    fall |-> !level);
endmodule

// File: rtl/din_evt_latch.sv
module din_evt_latch
  import din_evt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      rise,
  input  logic      fall,
  input  edge_sel_e sel,
  input  logic      clr,
  output logic      ev
);
  logic hit;

  assign hit = (sel[0] & rise) | (sel[1] & fall);

  always_ff @(posedge clk) begin
    if (rst) ev <= 1'b0;
    else     ev <= hit | (ev & ~clr);
  end

  // R6: a held event survives anything but a clear
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (ev && !clr) |=> ev);
  // R7: a clear with no edge empties the bit
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !ev);
  // R8: a counted edge always leaves the bit set, clear or not
  p_edge_wins_r8: assert property (@(posedge clk) disable iff (rst)
    hit |=> ev);
  // R4: a disabled select never sets an empty bit
  p_off_r4: assert property (@(posedge clk) disable iff (rst)
    (!ev && sel == EDGE_OFF) |=> !ev);
endmodule

// File: rtl/din_event_unit.sv
module din_event_unit
  import din_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   raw_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  logic [N_IN-1:0]   in_sync, level, rise, fall, ev, clr;
  logic [N_IN-1:0]   en_q;
  logic [2*N_IN-1:0] sel_q;
  logic [DEB_W-1:0]  reload_q;
  logic [7:0]        rd_next;

  din_evt_sync #(.W(N_IN)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(in_sync)
  );

  for (genvar i = 0; i < N_IN; i++) begin : g_ch
    din_evt_debounce #(.CNT_W(DEB_W)) u_deb (
      .clk(clk), .rst(rst), .in_sync(in_sync[i]), .reload(reload_q),
      .level(level[i]), .rise(rise[i]), .fall(fall[i])
    );
    assign clr[i] = bus_we && (bus_addr == ADDR_W'(OFS_EV + i / 8))
                    && bus_wdata[i % 8];
    din_evt_latch u_lat (
      .clk(clk), .rst(rst), .rise(rise[i]), .fall(fall[i]),
      .sel(edge_sel_e'(sel_q[2*i +: 2])), .clr(clr[i]), .ev(ev[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= DEB_W'(DEB_DEFAULT);
      en_q     <= '0;
      sel_q    <= '0;
    end else if (bus_we) begin
      if (bus_addr == ADDR_W'(OFS_RL_LO)) reload_q[7:0]  <= bus_wdata;
      if (bus_addr == ADDR_W'(OFS_RL_HI)) reload_q[15:8] <= bus_wdata;
      for (int b = 0; b < NB; b++)
        if (bus_addr == ADDR_W'(OFS_EN + b)) en_q[8*b +: 8] <= bus_wdata;
      for (int q = 0; q < NSEL_B; q++)
        if (bus_addr == ADDR_W'(OFS_SEL + q)) sel_q[8*q +: 8] <= bus_wdata;
    end
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == ADDR_W'(OFS_RL_LO)) rd_next = reload_q[7:0];
    if (bus_addr == ADDR_W'(OFS_RL_HI)) rd_next = reload_q[15:8];
    for (int b = 0; b < NB; b++) begin
      if (bus_addr == ADDR_W'(OFS_ST + b)) rd_next = level[8*b +: 8];
      if (bus_addr == ADDR_W'(OFS_EV + b)) rd_next = ev[8*b +: 8];
      if (bus_addr == ADDR_W'(OFS_EN + b)) rd_next = en_q[8*b +: 8];
    end
    for (int q = 0; q < NSEL_B; q++)
      if (bus_addr == ADDR_W'(OFS_SEL + q)) rd_next = sel_q[8*q +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      irq       <= |(ev & en_q);
    end
  end

  // R9: an enabled pending event raises the request on the next edge
  p_irq_raise_r9: assert property (@(posedge clk) disable iff (rst)
    (|(ev & en_q)) |=> irq);
  // R9: the request only drops once no enabled event remains
  p_irq_drop_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past((ev & en_q) == '0));
endmodule

// File: tb/din_event_unit_tb.sv
module din_event_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int L = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] raw_in = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] st_m, ev_m, en_m;
  logic [31:0] sel_m;

  din_event_unit dut_i (
    .clk(clk), .rst(rst), .raw_in(raw_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] hits(logic [15:0] prev, logic [15:0] nxt,
                                       logic [31:0] sel);
    logic [15:0] h = '0;
    for (int i = 0; i < 16; i++) begin
      if (!prev[i] && nxt[i] && sel[2*i])   h[i] = 1'b1;
      if (prev[i] && !nxt[i] && sel[2*i+1]) h[i] = 1'b1;
    end
    return h;
  endfunction

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    bus_addr = a[3:0]; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    bus_addr = a[3:0];
    @(posedge clk); #1;
    d = bus_rdata;
  endtask

  task automatic rd16(int a, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 1, hi);
    d = {hi, lo};
  endtask

  task automatic apply(logic [15:0] v);
    raw_in = v;
    repeat (L + 12) @(posedge clk);
    #1;
    ev_m = ev_m | hits(st_m, v, sel_m);
    st_m = v;
  endtask

  task automatic check_all(string req);
    logic [15:0] s, e;
    rd16(1, s); chk({req, " status"}, s, st_m);
    rd16(3, e); chk({req, " event"}, e, ev_m);
    repeat (2) @(posedge clk); #1;
    chk({req, " irq"}, irq, |(ev_m & en_m));
  endtask

  task automatic write_sel();
    for (int q = 0; q < 4; q++) wr(7 + q, sel_m[8*q +: 8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    void'($urandom(32'd2024));
    st_m = '0; ev_m = '0; en_m = '0; sel_m = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 rdata", bus_rdata, 0);
    rd(0, b);   chk("R1 reload lo", b, 8);
    rd(7, b);   chk("R1 sel", b, 0);
    rd16(5, w); chk("R1 enable", w, 0);
    check_all("R1");

    wr(0, L[7:0]); wr(11, 8'h00);

    // R3 glitch of L synchronized cycles is dropped
    raw_in = 16'h0001;
    repeat (L) @(posedge clk);
    #1 raw_in = 16'h0000;
    repeat (12) @(posedge clk); #1;
    rd16(1, w); chk("R3 glitch", w, 0);
    // R3 exactly L+1 cycles is accepted
    raw_in = 16'h0100;
    repeat (L + 1) @(posedge clk);
    #1 raw_in = 16'h0000;
    repeat (3) @(posedge clk); #1;
    rd16(1, w); chk("R3 threshold R2 high byte", w, 16'h0100);
    repeat (12) @(posedge clk); #1;
    rd16(1, w); chk("R3 return", w, 0);

    // R4 input0 rising, input1 falling, input2 both, input3 off
    sel_m = 32'h0000_0039; write_sel();
    apply(16'h000F); check_all("R4 R5 rise");
    apply(16'h0000); check_all("R4 R5 fall");
    // R6 further edges on held bits
    apply(16'h0005); apply(16'h0000); check_all("R6 sticky");
    // R7 zero write keeps, one write clears
    wr(3, 8'h00); check_all("R7 zero write");
    wr(3, 8'h02); ev_m &= ~16'h0002; check_all("R7 clear");
    // R9 interrupt only on enabled bits
    wr(5, 8'h04); wr(6, 8'h00); en_m = 16'h0004; check_all("R9 raise");
    wr(3, 8'h01); ev_m &= ~16'h0001; check_all("R9 other clear");
    wr(3, 8'h04); ev_m &= ~16'h0004; check_all("R9 drop");

    // R8 falling edge on input2 collides with its clear
    apply(16'h0004); check_all("R8 setup");
    raw_in = 16'h0000;
    repeat (L + 3) @(posedge clk);
    #1 bus_addr = 4'd3; bus_wdata = 8'h04; bus_we = 1'b1;
    @(posedge clk); #1 bus_we = 1'b0;
    repeat (8) @(posedge clk); #1;
    st_m = 16'h0000;
    check_all("R8 edge wins");
    wr(3, 8'h04); ev_m &= ~16'h0004; check_all("R8 later clear");

    // random traffic
    for (int it = 0; it < 120; it++) begin
      logic [15:0] v, m;
      if (it % 10 == 0) begin
        sel_m = $urandom; write_sel();
        en_m = 16'($urandom);
        wr(5, en_m[7:0]); wr(6, en_m[15:8]);
      end
      v = 16'($urandom);
      apply(v);
      check_all("R5 R6 R9 random");
      m = 16'($urandom);
      wr(3, m[7:0]); wr(4, m[15:8]);
      ev_m &= ~m;
      check_all("R7 random clear");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule